// File: doc/BRIEF.md
# Snooze Power-Down Sequencer

This block sequences a synchronous memory into and out of a low-power snooze state. A sleep request arrives asynchronously and active high; the block brings it into the clock domain through a flop chain, counts clock cycles, and then raises the flags that the rest of the device uses to stop sampling its inputs and to float its data outputs. The stored contents stay intact while asleep. The memory core is told to hold them, and the block does no work of its own to keep them.

When the request is withdrawn, the block counts the exit latency, lets input sampling resume, and opens a short recovery window. During that window only deselect and read commands reach the core. A write or a burst start is turned into a deselect, and a one-cycle error pulse is raised for each cycle in which one is attempted. A command that is in flight when sleep takes hold is simply dropped. Completion of such a command is not guaranteed.

The command path is a filter that sits between the device's command decoder and its core. Entry latency, exit latency, synchronizer depth and recovery length are parameters. Both latencies are counted from the first rising edge that samples the changed request, so the synchronizer delay is part of the latency.

Top module: `snooze_seq`

## Requirements
- R1: While reset is held and in the cycles after it is released, `in_ignore`, `out_hiz`, `asleep`, `recovering` and `op_err` are 0. With no request, `op_grant` equals `op_cmd`.
- R2: When `sleep_req` rises, `in_ignore`, `out_hiz` and `asleep` rise together at the second rising edge after the first edge that samples the request high (ENTRY_LAT = 2). They stay low after that first edge and after the next one.
- R3: When `sleep_req` falls, `in_ignore`, `out_hiz` and `asleep` stay high through the next two edges. They fall, and `recovering` rises, at the second edge after the first edge that samples the request low (EXIT_LAT = 2).
- R4: While `in_ignore` is 1, `op_grant` is 0 (deselect) and `op_err` is 0 for every value of `op_cmd`.
- R5: `recovering` stays high for exactly REC_CYC = 2 cycles and then falls, with all flags low.
- R6: During recovery, `op_cmd` values 0 (deselect) and 1 (read) pass to `op_grant` unchanged, and `op_err` is 0.
- R7: During recovery, `op_cmd` values 2 (write) and 3 (burst start) give `op_grant` = 0 and `op_err` = 1 in that same cycle. Outside recovery, `op_err` is 0.
- R8: While awake and not recovering, `op_grant` equals `op_cmd` for all four codes, and `op_err` is 0.
- R9: A command held across entry is passed in the cycle before `in_ignore` rises and is dropped (`op_grant` = 0) from the cycle in which it rises.
- R10: A request raised during the recovery window re-enters sleep with the same two-cycle latency, counted from its first sampling edge. Recovery ends normally in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sleep_req | input | 1 | Asynchronous active-high snooze request |
| op_cmd | input | 2 | Decoded command: 0 deselect, 1 read, 2 write, 3 burst start |
| in_ignore | output | 1 | Inputs other than the request must be ignored |
| out_hiz | output | 1 | Data outputs must be high-impedance |
| asleep | output | 1 | Device is in the snooze state |
| recovering | output | 1 | Exit recovery window is open |
| op_grant | output | 2 | Command passed to the core, same encoding as op_cmd |
| op_err | output | 1 | Write or burst start rejected during recovery |

## Verification
The assertions assume that `op_cmd` is stable between clock edges. They also assume that `sleep_req` changes at most once per cycle, away from the rising edge, so that each synchronizer stage equals its neighbour one cycle earlier. The bench drives every input two nanoseconds after a rising edge and samples one nanosecond later, so both the request and the commands are settled well before the next edge. The request is held for many cycles in each phase, except in the deliberate re-request inside the recovery window.

// File: rtl/snz_pkg.sv
package snz_pkg;

  typedef enum logic [1:0] {
    OP_DESEL = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_BURST = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_AWAKE    = 3'd0,
    ST_ENTERING = 3'd1,
    ST_ASLEEP   = 3'd2,
    ST_WAKING   = 3'd3,
    ST_RECOVER  = 3'd4
  } snz_state_e;

endpackage

// File: rtl/snz_sync.sv
module snz_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] ff_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) ff_q[gi] <= 1'b0;
          else        ff_q[gi] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) ff_q[gi] <= 1'b0;
          else        ff_q[gi] <= ff_q[gi-1];
        end
        // each stage carries its neighbour one cycle late (R2, R3 latency)
        assert_sync_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
          ff_q[gi] == $past(ff_q[gi-1]));
      end
    end
  endgenerate

  assign q_sync = ff_q[STAGES-1];

endmodule

// File: rtl/snz_fsm.sv
module snz_fsm
  import snz_pkg::*;
#(
  parameter int ENTRY_LAT   = 2,
  parameter int EXIT_LAT    = 2,
  parameter int SYNC_STAGES = 2,
  parameter int REC_CYC     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_s,
  output logic ignore_o,
  output logic hiz_o,
  output logic asleep_o,
  output logic rec_o
);

  localparam int ENT_X = (ENTRY_LAT > SYNC_STAGES) ? ENTRY_LAT - SYNC_STAGES : 0;
  localparam int EXT_X = (EXIT_LAT > SYNC_STAGES) ? EXIT_LAT - SYNC_STAGES : 0;
  localparam int REC_N = (REC_CYC > 0) ? REC_CYC : 1;
  localparam int MAXV  = (ENT_X > EXT_X) ? ((ENT_X > REC_N) ? ENT_X : REC_N)
                                         : ((EXT_X > REC_N) ? EXT_X : REC_N);
  localparam int CW    = $clog2(MAXV + 2);
  localparam logic [CW-1:0] ENT_LD = CW'((ENT_X > 0) ? ENT_X - 1 : 0);
  localparam logic [CW-1:0] EXT_LD = CW'((EXT_X > 0) ? EXT_X - 1 : 0);
  localparam logic [CW-1:0] REC_LD = CW'(REC_N - 1);

  snz_state_e      st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            cnt_en;
  logic            cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (st_q)
      ST_AWAKE, ST_RECOVER: begin
        if (req_s) begin
          cnt_en = 1'b1;
          if (ENT_X == 0) begin
            st_d = ST_ASLEEP;
          end else begin
            st_d  = ST_ENTERING;
            cnt_d = ENT_LD;
          end
        end else if (st_q == ST_RECOVER) begin
          cnt_en = 1'b1;
          if (cnt_zero) st_d = ST_AWAKE;
          else          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_ENTERING: begin
        cnt_en = 1'b1;
        if (cnt_zero) st_d = ST_ASLEEP;
        else          cnt_d = cnt_q - 1'b1;
      end
      ST_ASLEEP: begin
        if (!req_s) begin
          cnt_en = 1'b1;
          if (EXT_X == 0) begin
            st_d  = ST_RECOVER;
            cnt_d = REC_LD;
          end else begin
            st_d  = ST_WAKING;
            cnt_d = EXT_LD;
          end
        end
      end
      ST_WAKING: begin
        cnt_en = 1'b1;
        if (cnt_zero) begin
          st_d  = ST_RECOVER;
          cnt_d = REC_LD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        st_d = ST_AWAKE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_AWAKE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign ignore_o = (st_q == ST_ASLEEP) || (st_q == ST_WAKING);
  assign hiz_o    = (st_q == ST_ASLEEP) || (st_q == ST_WAKING);
  assign asleep_o = (st_q == ST_ASLEEP);
  assign rec_o    = (st_q == ST_RECOVER);

  // a synchronized request always moves an awake block toward sleep
  assert_entry_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_AWAKE && req_s) |=> (st_q == ST_ENTERING || st_q == ST_ASLEEP));

  // a removed request always leaves the sleep state on the next edge
  assert_exit_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ASLEEP && !req_s) |=> (st_q == ST_WAKING || st_q == ST_RECOVER));

  // sleep is only reached through a request seen one edge earlier
  assert_sleep_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep_o) |-> $past(req_s) || $past(st_q == ST_ENTERING));

endmodule

// File: rtl/snz_op_filter.sv
module snz_op_filter
  import snz_pkg::*;
(
  input  logic [1:0] cmd_i,
  input  logic       block_i,
  input  logic       restrict_i,
  output logic [1:0] cmd_o,
  output logic       err_o
);

  op_e cmd;
  logic illegal;

  assign cmd     = op_e'(cmd_i);
  assign illegal = (cmd == OP_WRITE) || (cmd == OP_BURST);

  always_comb begin
    cmd_o = cmd_i;
    err_o = 1'b0;
    if (block_i) begin
      cmd_o = OP_DESEL;
    end else if (restrict_i && illegal) begin
      cmd_o = OP_DESEL;
      err_o = 1'b1;
    end
  end

endmodule

// File: rtl/snooze_seq.sv
module snooze_seq
  import snz_pkg::*;
#(
  parameter int ENTRY_LAT   = 2,
  parameter int EXIT_LAT    = 2,
  parameter int SYNC_STAGES = 2,
  parameter int REC_CYC     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic [1:0] op_cmd,
  output logic       in_ignore,
  output logic       out_hiz,
  output logic       asleep,
  output logic       recovering,
  output logic [1:0] op_grant,
  output logic       op_err
);

  localparam int RLW = $clog2(REC_CYC + 2);

  logic [1:0] rst_sync_q;
  logic       rst_i;
  logic       req_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  snz_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk     (clk),
    .rst_n   (rst_i),
    .d_async (sleep_req),
    .q_sync  (req_s)
  );

  snz_fsm #(
    .ENTRY_LAT   (ENTRY_LAT),
    .EXIT_LAT    (EXIT_LAT),
    .SYNC_STAGES (SYNC_STAGES),
    .REC_CYC     (REC_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_i),
    .req_s    (req_s),
    .ignore_o (in_ignore),
    .hiz_o    (out_hiz),
    .asleep_o (asleep),
    .rec_o    (recovering)
  );

  snz_op_filter u_filter (
    .cmd_i      (op_cmd),
    .block_i    (in_ignore),
    .restrict_i (recovering),
    .cmd_o      (op_grant),
    .err_o      (op_err)
  );

  // run length of the recovery window, kept for the R5 check
  logic [RLW-1:0] rec_len_q;
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)                                rec_len_q <= '0;
    else if (!recovering)                      rec_len_q <= '0;
    else if (rec_len_q != {RLW{1'b1}})         rec_len_q <= rec_len_q + 1'b1;
  end

  assert_rec_len_R5: assert property (@(posedge clk) disable iff (!rst_i)
    recovering |-> (int'(rec_len_q) < REC_CYC));

  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_i)
    $countones({in_ignore, recovering}) <= 1);

  assert_ignore_blocks_R4: assert property (@(posedge clk) disable iff (!rst_i)
    in_ignore |-> (op_grant == OP_DESEL && !op_err));

  assert_reject_write_R7: assert property (@(posedge clk) disable iff (!rst_i)
    (recovering && op_cmd[1]) |-> (op_err && op_grant == OP_DESEL));

  assert_err_in_window_R7: assert property (@(posedge clk) disable iff (!rst_i)
    op_err |-> recovering);

  assert_exit_to_recover_R3: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(in_ignore) |-> recovering);

endmodule

// File: tb/snooze_seq_tb.sv
module snooze_seq_tb;

  logic       clk;
  logic       rst_n;
  logic       sleep_req;
  logic [1:0] op_cmd;
  logic       in_ignore, out_hiz, asleep, recovering, op_err;
  logic [1:0] op_grant;

  int nchk = 0;
  int nerr = 0;

  snooze_seq u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_req  (sleep_req),
    .op_cmd     (op_cmd),
    .in_ignore  (in_ignore),
    .out_hiz    (out_hiz),
    .asleep     (asleep),
    .recovering (recovering),
    .op_grant   (op_grant),
    .op_err     (op_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_flags(input string req, input int ign, input int hiz, input int slp, input int rec);
    chk(req, "in_ignore", int'(in_ignore), ign);
    chk(req, "out_hiz", int'(out_hiz), hiz);
    chk(req, "asleep", int'(asleep), slp);
    chk(req, "recovering", int'(recovering), rec);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; sleep_req = 1'b0; op_cmd = 2'd0;
    tick(3);
    chk_flags("R1", 0, 0, 0, 0);
    chk("R1", "op_err in reset", int'(op_err), 0);
    rst_n = 1'b1;
    tick(4);
    chk_flags("R1", 0, 0, 0, 0);
    op_cmd = 2'd2; #1;
    chk("R1", "op_grant after reset", int'(op_grant), 2);
    chk("R1", "op_err after reset", int'(op_err), 0);
  endtask

  task automatic t_awake();
    for (int op = 0; op < 4; op++) begin
      op_cmd = 2'(op); #1;
      chk("R8", "op_grant awake", int'(op_grant), op);
      chk("R8", "op_err awake", int'(op_err), 0);
    end
  endtask

  task automatic t_entry();
    op_cmd = 2'd2;
    sleep_req = 1'b1;
    tick(1);
    chk_flags("R2", 0, 0, 0, 0);
    tick(1);
    chk_flags("R2", 0, 0, 0, 0);
    chk("R9", "write before ignore", int'(op_grant), 2);
    tick(1);
    chk_flags("R2", 1, 1, 1, 0);
    chk("R9", "write dropped at entry", int'(op_grant), 0);
  endtask

  task automatic t_asleep();
    for (int op = 0; op < 4; op++) begin
      op_cmd = 2'(op); #1;
      chk("R4", "op_grant asleep", int'(op_grant), 0);
      chk("R4", "op_err asleep", int'(op_err), 0);
    end
    tick(5);
    chk_flags("R4", 1, 1, 1, 0);
  endtask

  task automatic t_exit();
    op_cmd = 2'd0;
    sleep_req = 1'b0;
    tick(1);
    chk_flags("R3", 1, 1, 1, 0);
    tick(1);
    chk_flags("R3", 1, 1, 1, 0);
    tick(1);
    chk_flags("R3", 0, 0, 0, 1);
    op_cmd = 2'd1; #1;
    chk("R6", "read in recovery", int'(op_grant), 1);
    chk("R6", "read err", int'(op_err), 0);
    op_cmd = 2'd2; #1;
    chk("R7", "write rejected", int'(op_grant), 0);
    chk("R7", "write err", int'(op_err), 1);
    tick(1);
    chk("R5", "recovering 2nd cycle", int'(recovering), 1);
    op_cmd = 2'd3; #1;
    chk("R7", "burst rejected", int'(op_grant), 0);
    chk("R7", "burst err", int'(op_err), 1);
    op_cmd = 2'd0; #1;
    chk("R6", "deselect in recovery", int'(op_grant), 0);
    chk("R6", "deselect err", int'(op_err), 0);
    tick(1);
    chk_flags("R5", 0, 0, 0, 0);
    op_cmd = 2'd2; #1;
    chk("R7", "write after window", int'(op_grant), 2);
    chk("R7", "no err after window", int'(op_err), 0);
  endtask

  task automatic t_reenter();
    op_cmd = 2'd0;
    sleep_req = 1'b1;
    tick(3);
    chk_flags("R10", 1, 1, 1, 0);
    sleep_req = 1'b0;
    tick(3);
    chk_flags("R10", 0, 0, 0, 1);
    sleep_req = 1'b1;
    tick(1);
    chk_flags("R10", 0, 0, 0, 1);
    tick(1);
    chk_flags("R10", 0, 0, 0, 0);
    tick(1);
    chk_flags("R10", 1, 1, 1, 0);
    sleep_req = 1'b0;
    tick(6);
    chk_flags("R10", 0, 0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_awake();
    t_entry();
    t_asleep();
    t_exit();
    t_reenter();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #4000000;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule